// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Target

This block models the device side of a three-wire serial EEPROM: chip select, serial clock and serial data in, plus a serial data out with an output-enable for an external tri-state pad. A small register array stands in for nonvolatile storage. The serial lines are sampled by the system clock and rising serial-clock edges are detected internally, so the whole model sits in one clock domain.

A frame begins with a start bit, followed by a two-bit opcode and an address sent MSB first. Read returns a leading zero and then the addressed word, and keeps streaming the following words while the serial clock runs. Write, erase, erase-all and write-all start a self-timed programming period whose length is a multiple of one parameter. During and after that period the data-out line reports ready/busy. A strap input chooses between 16-bit words and 8-bit bytes over the same storage.

Top module: `uwire_eeprom`

## Requirements
- R1: After reset the device is write-disabled, data-out is not driven, and every storage byte reads as all ones.
- R2: A frame is a 1 start bit, a two-bit opcode and an address sent MSB first, AW16 bits in x16 mode and AW16+1 bits in x8 mode. Opcodes are READ=10, WRITE=01 and ERASE=11. Opcode 00 is qualified by the two most significant address bits: 11 enables programming, 00 disables it, 10 is erase-all and 01 is write-all.
- R3: After the last address bit of a READ, data-out shows a 0 dummy bit. Each following serial-clock rising edge presents the next data bit, MSB first: 16 bits in x16 mode and 8 bits in x8 mode.
- R4: If the serial clock keeps running after a READ, the address advances on its own and the next word follows with no dummy bit. The address wraps from the last location to 0.
- R5: WRITE takes a 16-bit (x16) or 8-bit (x8) data field after the address. Programming starts on the edge that clocks in the last data bit, and afterwards the location holds that data.
- R6: ERASE sets every bit of the addressed word to 1, starting on the edge that clocks in the last address bit.
- R7: Erase-all sets the whole array to ones. The address bits below the two qualifier bits are don't-care.
- R8: Write-all stores its data field in every location, with an implied erase first. The address bits below the two qualifier bits are don't-care.
- R9: While chip select is high after a programming command, data-out is 0 while programming runs and 1 once it ends. A word program lasts 3*T_UNIT clocks, erase-all 8*T_UNIT and write-all 16*T_UNIT.
- R10: The ready/busy flag stays on data-out, with chip select high, until the next start bit. Chip select low disables the output, and the flag comes back when chip select returns high.
- R11: Once programming has started it runs to completion whatever chip select, serial clock and data-in do. Start bits during programming are not accepted.
- R12: When write-disabled (after reset or after the disable command), WRITE, ERASE, erase-all and write-all change nothing and start no busy period.
- R13: The x16 word k is made of byte 2k+1 (bits 15:8) and byte 2k (bits 7:0). The x8 address a selects byte a.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip select, active high |
| sk_i | input | 1 | Serial clock |
| di_i | input | 1 | Serial data in |
| org16_i | input | 1 | Organisation strap: 1 selects x16, 0 selects x8 |
| do_o | output | 1 | Serial data out or ready/busy flag |
| do_oe_o | output | 1 | Output enable for the data-out pad |

## Verification
The end of a programming period can coincide with serial activity from the host. The data-out flag flips to ready, the array commit happens, and a serial-clock edge may carry a would-be start bit, all in the same stretch of cycles. The bench provokes this by toggling chip select and clocking start/opcode bits inside a word-program window. It then checks three things: the flag still turns ready at the end, the written word is intact, and the ignored bits left no trace. A second overlap, the read pointer wrapping on the same edge that streams the last bit of the top word, is judged by the sequential read running across the array boundary in both organisations.

// File: rtl/uwire_pkg.sv
package uwire_pkg;

   typedef enum logic [2:0] {
      OP_NONE,
      OP_WRITE,
      OP_ERASE,
      OP_ERAL,
      OP_WRAL
   } op_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_OPC,
      ST_ADDR,
      ST_DATA,
      ST_READ,
      ST_HOLD
   } st_e;

   localparam logic [1:0] OPC_READ  = 2'b10;
   localparam logic [1:0] OPC_WRITE = 2'b01;
   localparam logic [1:0] OPC_ERASE = 2'b11;
   localparam logic [1:0] OPC_EXT   = 2'b00;

   localparam logic [1:0] EXT_WEN   = 2'b11;
   localparam logic [1:0] EXT_WDIS  = 2'b00;
   localparam logic [1:0] EXT_ERAL  = 2'b10;
   localparam logic [1:0] EXT_WRAL  = 2'b01;

endpackage

// File: rtl/uwire_prog_timer.sv
module uwire_prog_timer
   import uwire_pkg::*;
#(
   parameter int T_UNIT = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  op_e  op_i,
   output logic busy_o,
   output logic done_o
);

   localparam int MAX_CYC = 16 * T_UNIT;
   localparam int CW      = $clog2(MAX_CYC + 1);

   generate
      if (T_UNIT < 1) begin : g_bad_unit
         $error("uwire_prog_timer: T_UNIT must be at least 1");
      end
   endgenerate

   logic [CW-1:0] dur;
   logic [CW-1:0] cnt_q;

   always_comb begin
      unique case (op_i)
         OP_ERAL: dur = CW'(8 * T_UNIT);
         OP_WRAL: dur = CW'(16 * T_UNIT);
         default: dur = CW'(3 * T_UNIT);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (start_i) begin
         cnt_q <= dur;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - CW'(1);
      end
   end

   assign busy_o = (cnt_q != '0);
   assign done_o = (cnt_q == CW'(1));

endmodule

// File: rtl/uwire_array.sv
module uwire_array
   import uwire_pkg::*;
#(
   parameter int         AW16      = 6,
   parameter logic [7:0] INIT_BYTE = 8'hFF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             org16_i,
   input  logic             commit_i,
   input  op_e              op_i,
   input  logic [AW16:0]    op_addr_i,
   input  logic [15:0]      op_data_i,
   input  logic [AW16:0]    rd_addr_i,
   output logic [15:0]      rd_word_o
);

   localparam int AWX    = AW16 + 1;
   localparam int NBYTES = 1 << AWX;

   generate
      if (AW16 < 3 || AW16 > 10) begin : g_bad_aw
         $error("uwire_array: AW16 must lie in 3..10");
      end
   endgenerate

   logic [7:0] mem_q [NBYTES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NBYTES; i++) begin
            mem_q[i] <= INIT_BYTE;
         end
      end else if (commit_i) begin
         for (int i = 0; i < NBYTES; i++) begin
            logic       hit;
            logic [7:0] wb;
            hit = org16_i ? (op_addr_i[AW16-1:0] == i[AWX-1:1])
                          : (op_addr_i == i[AWX-1:0]);
            wb  = (org16_i && i[0]) ? op_data_i[15:8] : op_data_i[7:0];
            unique case (op_i)
               OP_WRITE: if (hit) mem_q[i] <= wb;
               OP_ERASE: if (hit) mem_q[i] <= 8'hFF;
               OP_ERAL:  mem_q[i] <= 8'hFF;
               OP_WRAL:  mem_q[i] <= wb;
               default:  ;
            endcase
         end
      end
   end

   always_comb begin
      if (org16_i) begin
         rd_word_o = {mem_q[{rd_addr_i[AW16-1:0], 1'b1}],
                      mem_q[{rd_addr_i[AW16-1:0], 1'b0}]};
      end else begin
         rd_word_o = {mem_q[rd_addr_i], 8'h00};
      end
   end

endmodule

// File: rtl/uwire_ctrl.sv
module uwire_ctrl
   import uwire_pkg::*;
#(
   parameter int AW16 = 6
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cs_i,
   input  logic           sk_i,
   input  logic           di_i,
   input  logic           org16_i,
   input  logic           busy_i,
   input  logic [15:0]    rd_word_i,
   output logic [AW16:0]  rd_addr_o,
   output logic           start_o,
   output op_e            op_o,
   output logic [AW16:0]  op_addr_o,
   output logic [15:0]    op_data_o,
   output logic           wen_o,
   output logic           stat_en_o,
   output logic           do_o,
   output logic           do_oe_o
);

   localparam int AWX  = AW16 + 1;
   localparam int CNTW = $clog2(((AWX > 16) ? AWX : 16) + 1);
   localparam logic [AWX-1:0] MASK16 = {1'b0, {AW16{1'b1}}};

   logic           cs_q, sk_q, sk_qq, di_q;
   logic           rise;
   st_e            state_q;
   logic [CNTW-1:0] cnt_q;
   logic [1:0]     opc_q;
   logic [AWX-1:0] addr_q;
   logic [15:0]    data_q;
   logic [AWX-1:0] rd_ptr_q;
   logic [15:0]    rd_sh_q;
   logic           out_q;
   logic           wen_q;
   logic           stat_en_q;
   logic           start_q;
   op_e            op_q;
   logic [AWX-1:0] op_addr_q;
   logic [15:0]    op_data_q;

   logic [AWX-1:0]  addr_full, addr_next, ptr_inc;
   logic [1:0]      ext;
   logic [15:0]     data_full;
   logic [CNTW-1:0] aw_last, dw_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q  <= 1'b0;
         sk_q  <= 1'b0;
         sk_qq <= 1'b0;
         di_q  <= 1'b0;
      end else begin
         cs_q  <= cs_i;
         sk_q  <= sk_i;
         sk_qq <= sk_q;
         di_q  <= di_i;
      end
   end

   assign rise = cs_q & sk_q & ~sk_qq;

   always_comb begin
      addr_full = {addr_q[AWX-2:0], di_q};
      addr_next = org16_i ? (addr_full & MASK16) : addr_full;
      ext       = org16_i ? addr_next[AW16-1 -: 2] : addr_next[AWX-1 -: 2];
      ptr_inc   = rd_ptr_q + AWX'(1);
      if (org16_i) ptr_inc = ptr_inc & MASK16;
      data_full = {data_q[14:0], di_q};
      aw_last   = org16_i ? CNTW'(AW16 - 1) : CNTW'(AW16);
      dw_last   = org16_i ? CNTW'(15) : CNTW'(7);
      rd_addr_o = (state_q == ST_ADDR) ? addr_next : ptr_inc;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         cnt_q     <= '0;
         opc_q     <= '0;
         addr_q    <= '0;
         data_q    <= '0;
         rd_ptr_q  <= '0;
         rd_sh_q   <= '0;
         out_q     <= 1'b0;
         wen_q     <= 1'b0;
         stat_en_q <= 1'b0;
         start_q   <= 1'b0;
         op_q      <= OP_NONE;
         op_addr_q <= '0;
         op_data_q <= '0;
      end else begin
         start_q <= 1'b0;
         if (!cs_q) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
         end else if (rise) begin
            unique case (state_q)
               ST_IDLE: begin
                  if (!busy_i && di_q) begin
                     state_q   <= ST_OPC;
                     cnt_q     <= '0;
                     stat_en_q <= 1'b0;
                  end
               end
               ST_OPC: begin
                  opc_q <= {opc_q[0], di_q};
                  if (cnt_q == CNTW'(1)) begin
                     state_q <= ST_ADDR;
                     cnt_q   <= '0;
                  end else begin
                     cnt_q <= cnt_q + CNTW'(1);
                  end
               end
               ST_ADDR: begin
                  addr_q <= addr_full;
                  if (cnt_q != aw_last) begin
                     cnt_q <= cnt_q + CNTW'(1);
                  end else begin
                     cnt_q <= '0;
                     unique case (opc_q)
                        OPC_READ: begin
                           state_q  <= ST_READ;
                           rd_ptr_q <= addr_next;
                           rd_sh_q  <= rd_word_i;
                           out_q    <= 1'b0;
                        end
                        OPC_ERASE: begin
                           op_q      <= OP_ERASE;
                           op_addr_q <= addr_next;
                           if (wen_q) begin
                              start_q   <= 1'b1;
                              stat_en_q <= 1'b1;
                              state_q   <= ST_IDLE;
                           end else begin
                              state_q <= ST_HOLD;
                           end
                        end
                        OPC_WRITE: begin
                           op_q      <= OP_WRITE;
                           op_addr_q <= addr_next;
                           state_q   <= ST_DATA;
                        end
                        default: begin
                           unique case (ext)
                              EXT_WEN: begin
                                 wen_q   <= 1'b1;
                                 state_q <= ST_HOLD;
                              end
                              EXT_WDIS: begin
                                 wen_q   <= 1'b0;
                                 state_q <= ST_HOLD;
                              end
                              EXT_ERAL: begin
                                 op_q <= OP_ERAL;
                                 if (wen_q) begin
                                    start_q   <= 1'b1;
                                    stat_en_q <= 1'b1;
                                    state_q   <= ST_IDLE;
                                 end else begin
                                    state_q <= ST_HOLD;
                                 end
                              end
                              default: begin
                                 op_q    <= OP_WRAL;
                                 state_q <= ST_DATA;
                              end
                           endcase
                        end
                     endcase
                  end
               end
               ST_DATA: begin
                  data_q <= data_full;
                  if (cnt_q != dw_last) begin
                     cnt_q <= cnt_q + CNTW'(1);
                  end else begin
                     cnt_q     <= '0;
                     op_data_q <= org16_i ? data_full : {8'h00, data_full[7:0]};
                     if (wen_q) begin
                        start_q   <= 1'b1;
                        stat_en_q <= 1'b1;
                        state_q   <= ST_IDLE;
                     end else begin
                        state_q <= ST_HOLD;
                     end
                  end
               end
               ST_READ: begin
                  out_q <= rd_sh_q[15];
                  if (cnt_q == dw_last) begin
                     cnt_q    <= '0;
                     rd_sh_q  <= rd_word_i;
                     rd_ptr_q <= ptr_inc;
                  end else begin
                     cnt_q   <= cnt_q + CNTW'(1);
                     rd_sh_q <= {rd_sh_q[14:0], 1'b0};
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign start_o   = start_q;
   assign op_o      = op_q;
   assign op_addr_o = op_addr_q;
   assign op_data_o = op_data_q;
   assign wen_o     = wen_q;
   assign stat_en_o = stat_en_q;
   assign do_oe_o   = cs_q & (stat_en_q | (state_q == ST_READ));
   assign do_o      = do_oe_o & (stat_en_q ? ~busy_i : out_q);

endmodule

// File: rtl/uwire_eeprom.sv
module uwire_eeprom
   import uwire_pkg::*;
#(
   parameter int         AW16      = 6,
   parameter int         T_UNIT    = 32,
   parameter logic [7:0] INIT_BYTE = 8'hFF
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_i,
   input  logic sk_i,
   input  logic di_i,
   input  logic org16_i,
   output logic do_o,
   output logic do_oe_o
);

   localparam int AWX = AW16 + 1;

   logic           prog_start;
   logic           prog_busy;
   logic           prog_done;
   logic           wr_en;
   logic           stat_en;
   op_e            op;
   logic [AWX-1:0] op_addr;
   logic [15:0]    op_data;
   logic [AWX-1:0] rd_addr;
   logic [15:0]    rd_word;

   uwire_ctrl #(.AW16(AW16)) i_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_i      (cs_i),
      .sk_i      (sk_i),
      .di_i      (di_i),
      .org16_i   (org16_i),
      .busy_i    (prog_busy),
      .rd_word_i (rd_word),
      .rd_addr_o (rd_addr),
      .start_o   (prog_start),
      .op_o      (op),
      .op_addr_o (op_addr),
      .op_data_o (op_data),
      .wen_o     (wr_en),
      .stat_en_o (stat_en),
      .do_o      (do_o),
      .do_oe_o   (do_oe_o)
   );

   uwire_prog_timer #(.T_UNIT(T_UNIT)) i_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (prog_start),
      .op_i    (op),
      .busy_o  (prog_busy),
      .done_o  (prog_done)
   );

   uwire_array #(.AW16(AW16), .INIT_BYTE(INIT_BYTE)) i_array (
      .clk       (clk),
      .rst_n     (rst_n),
      .org16_i   (org16_i),
      .commit_i  (prog_done),
      .op_i      (op),
      .op_addr_i (op_addr),
      .op_data_i (op_data),
      .rd_addr_i (rd_addr),
      .rd_word_o (rd_word)
   );

endmodule

// File: rtl/uwire_eeprom_chk.sv
module uwire_eeprom_chk (
   input logic clk,
   input logic rst_n,
   input logic cs_i,
   input logic do_oe_o,
   input logic busy,
   input logic start,
   input logic wen,
   input logic stat_en
);

   a_r10_standby_hiz: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_i |=> !do_oe_o);

   a_r10_status_armed: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> stat_en);

   a_r9_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy);

   a_r11_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !start);

   a_r12_locked: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> wen);

endmodule

bind uwire_eeprom uwire_eeprom_chk i_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .cs_i    (cs_i),
   .do_oe_o (do_oe_o),
   .busy    (prog_busy),
   .start   (prog_start),
   .wen     (wr_en),
   .stat_en (stat_en)
);

// File: tb/test_uwire_eeprom.sv
module test_uwire_eeprom;

   localparam int T_UNIT = 32;
   localparam int T_WORD = 3 * T_UNIT;
   localparam int T_ERAL = 8 * T_UNIT;
   localparam int T_WRAL = 16 * T_UNIT;

   // {org16, addr[6:0], data[15:0]}
   localparam logic [23:0] VEC [6] = '{
      {1'b1, 7'd0,   16'hA5C3},
      {1'b1, 7'd63,  16'h1234},
      {1'b1, 7'd10,  16'h0F0F},
      {1'b0, 7'd7,   16'h005A},
      {1'b0, 7'd126, 16'h00C6},
      {1'b1, 7'd3,   16'hBEEF}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs = 1'b0, sk = 1'b0, di = 1'b0, org16 = 1'b1;
   logic do_w, do_oe;
   int   n_chk = 0;
   int   n_err = 0;

   always #5 clk = ~clk;

   uwire_eeprom #(.AW16(6), .T_UNIT(T_UNIT)) i_uwire_eeprom (
      .clk     (clk),
      .rst_n   (rst_n),
      .cs_i    (cs),
      .sk_i    (sk),
      .di_i    (di),
      .org16_i (org16),
      .do_o    (do_w),
      .do_oe_o (do_oe)
   );

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic bit_out(input logic b);
      di = b;
      repeat (2) @(negedge clk);
      sk = 1'b1;
      repeat (4) @(negedge clk);
      sk = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic send_bits(input logic [15:0] v, input int n);
      for (int i = n - 1; i >= 0; i--) bit_out(v[i]);
   endtask

   task automatic deselect();
      cs = 1'b0; sk = 1'b0; di = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic cmd(input logic [1:0] opc, input logic [6:0] a);
      cs = 1'b1;
      repeat (2) @(negedge clk);
      bit_out(1'b1);
      send_bits({14'd0, opc}, 2);
      send_bits({9'd0, a}, org16 ? 6 : 7);
   endtask

   task automatic get_word(output logic [15:0] w);
      w = '0;
      for (int i = 0; i < (org16 ? 16 : 8); i++) begin
         bit_out(1'b0);
         w = {w[14:0], do_w};
      end
   endtask

   task automatic rd(input logic [6:0] a, output logic [15:0] w, input string tag);
      cmd(2'b10, a);
      chk({tag, " dummy bit"}, {15'd0, do_w}, 16'h0000);
      chk({tag, " oe while reading"}, {15'd0, do_oe}, 16'h0001);
      get_word(w);
   endtask

   task automatic wait_ready(input int dur, input string tag);
      chk({tag, " busy at start"}, {14'd0, do_oe, do_w}, 16'h0002);
      repeat (dur - 12) @(negedge clk);
      chk({tag, " busy near end"}, {14'd0, do_oe, do_w}, 16'h0002);
      repeat (20) @(negedge clk);
      chk({tag, " ready after"}, {14'd0, do_oe, do_w}, 16'h0003);
   endtask

   task automatic wen_cmd(input logic en);
      cmd(2'b00, en ? (org16 ? 7'h30 : 7'h60) : 7'h00);
      deselect();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      logic [15:0] w;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1: reset state
      chk("R1 oe after reset", {15'd0, do_oe}, 16'h0000);
      rd(7'd5, w, "R1 R3 read after reset");
      chk("R1 array ones", w, 16'hFFFF);
      deselect();

      // R12: write while disabled after reset
      cmd(2'b01, 7'd5); send_bits(16'h0000, 16);
      chk("R12 no status when disabled", {15'd0, do_oe}, 16'h0000);
      deselect();
      rd(7'd5, w, "R12 readback");
      chk("R12 word unchanged", w, 16'hFFFF);
      deselect();

      // R2: enable, then walk the vector table
      wen_cmd(1'b1);
      for (int k = 0; k < 6; k++) begin
         org16 = VEC[k][23];
         cmd(2'b01, VEC[k][22:16]);
         send_bits(VEC[k][15:0], org16 ? 16 : 8);
         wait_ready(T_WORD, "R5 R9 write");
         deselect();
         chk("R10 standby hiz", {15'd0, do_oe}, 16'h0000);
         rd(VEC[k][22:16], w, "R3 R2 vector read");
         chk("R5 vector data", w, org16 ? VEC[k][15:0] : {8'h00, VEC[k][7:0]});
         deselect();
      end

      // R13: byte mapping
      org16 = 1'b0;
      rd(7'd0, w, "R13 byte 0");   chk("R13 low byte of word 0", w, 16'h00C3); deselect();
      rd(7'd1, w, "R13 byte 1");   chk("R13 high byte of word 0", w, 16'h00A5); deselect();
      rd(7'd7, w, "R13 byte 7");   chk("R13 high byte of word 3", w, 16'h00BE); deselect();

      // R4: sequential read with wrap, both organisations
      rd(7'd126, w, "R4 x8 seq");  chk("R4 x8 first", w, 16'h00C6);
      get_word(w);                 chk("R4 x8 second", w, 16'h0012);
      get_word(w);                 chk("R4 x8 wrap", w, 16'h00C3);
      deselect();
      org16 = 1'b1;
      rd(7'd63, w, "R4 x16 seq");  chk("R4 x16 first", w, 16'h12C6);
      get_word(w);                 chk("R4 x16 wrap", w, 16'hA5C3);
      get_word(w);                 chk("R4 x16 third", w, 16'hFFFF);
      deselect();

      // R6 and R10: erase word, status persistence
      cmd(2'b11, 7'd10);
      wait_ready(T_WORD, "R6 R9 erase");
      bit_out(1'b0); bit_out(1'b0);
      chk("R10 status holds over zeros", {14'd0, do_oe, do_w}, 16'h0003);
      deselect();
      chk("R10 hiz on deselect", {15'd0, do_oe}, 16'h0000);
      cs = 1'b1; repeat (4) @(negedge clk);
      chk("R10 status back on select", {14'd0, do_oe, do_w}, 16'h0003);
      rd(7'd10, w, "R6 R10 read after start");
      chk("R6 erased word", w, 16'hFFFF);
      deselect();

      // R11: activity during programming is ignored
      cmd(2'b01, 7'd20); send_bits(16'h1111, 16);
      chk("R11 busy", {14'd0, do_oe, do_w}, 16'h0002);
      deselect();
      cs = 1'b1; repeat (2) @(negedge clk);
      bit_out(1'b1); bit_out(1'b1); bit_out(1'b0);
      deselect();
      cs = 1'b1;
      repeat (T_WORD) @(negedge clk);
      chk("R11 ready after toggling", {14'd0, do_oe, do_w}, 16'h0003);
      deselect();
      rd(7'd20, w, "R11 read");    chk("R11 word intact", w, 16'h1111); deselect();
      rd(7'd21, w, "R11 read nb"); chk("R11 neighbour intact", w, 16'hFFFF); deselect();

      // R12: after disable, erase and write-all ignored
      wen_cmd(1'b0);
      cmd(2'b11, 7'd20);
      chk("R12 erase disabled no status", {15'd0, do_oe}, 16'h0000);
      deselect();
      cmd(2'b00, 7'h10); send_bits(16'h9999, 16);
      chk("R12 wral disabled no status", {15'd0, do_oe}, 16'h0000);
      deselect();
      rd(7'd20, w, "R12 read"); chk("R12 word kept", w, 16'h1111); deselect();

      // R7: erase-all with don't-care low bits
      wen_cmd(1'b1);
      cmd(2'b00, 7'h2B);
      wait_ready(T_ERAL, "R7 R9 eral");
      deselect();
      rd(7'd0, w, "R7 read 0");   chk("R7 word 0 ones", w, 16'hFFFF); deselect();
      rd(7'd20, w, "R7 read 20"); chk("R7 word 20 ones", w, 16'hFFFF); deselect();

      // R8: write-all in x8 with don't-care low bits
      org16 = 1'b0;
      cmd(2'b00, 7'h3F); send_bits(16'h003C, 8);
      wait_ready(T_WRAL, "R8 R9 wral");
      deselect();
      org16 = 1'b1;
      rd(7'd5, w, "R8 read 5");   chk("R8 word 5", w, 16'h3C3C); deselect();
      rd(7'd63, w, "R8 read 63"); chk("R8 word 63", w, 16'h3C3C); deselect();

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule